// File: doc/BRIEF.md
# Bus I/O Decoder with Double-Buffered 12-bit DAC Register

This block sits on the external bus of a small 8-bit controller: a 16-bit address, a byte of write data, and three active-low controls (read, write, program fetch). In the lower half of the address space it decodes 4 KiB pages into strobes for the peripherals of a signal generator. These are an 8-bit DAC input latch, a character LCD, and a 10-bit ADC. It also produces the shared memory read strobe used by program and data memory.

A 12-bit DAC is held inside the decoder and is double-buffered. Firmware writes the low byte and the high nibble into two input latches. It then writes to a separate page, and that write copies both latches into the output register in one step. The analog output therefore never shows a half-updated code.

All strobes are combinational from the bus. Register updates are synchronous to `clk`. Each write is taken on the rising edge of the write strobe, using the address and data sampled while the strobe was low.

Top module: `bus_io_decoder`

## Requirements
- R1: Peripheral strobes (dac8_cs_n, lcd_en, adc_start_n, adc_rd_hi_n, adc_rd_lo_n) are all inactive unless address bit 15 is 0, bus_psen_n is 1, and bus_rd_n or bus_wr_n is 0.
- R2: dac8_cs_n is 0 only for a write (bus_wr_n = 0) to page 0 (address bits 14:12 = 0); a read there leaves it at 1.
- R3: For a read or write to page 1, lcd_en is 1, lcd_rs equals address bit 0 and lcd_rw equals address bit 1; outside page 1 all three are 0.
- R4: On page 2 a write drives adc_start_n to 0. A read drives adc_rd_hi_n to 0 when address bit 0 is 1, and adc_rd_lo_n to 0 when it is 0. At most one of the three is 0 at any time.
- R5: A write to page 4 loads bus_data into the low DAC latch when address bit 0 is 0. When bit 0 is 1 it loads the high latch, which keeps only bus_data bits 3:0 as code bits 11:8.
- R6: dac12_code changes only after a write to page 5, which copies {high latch, low latch} into it; latch loads alone leave it unchanged.
- R7: Accesses to pages 3, 6 and 7 produce no strobe and do not change dac12_code.
- R8: mem_rd_n is 0 exactly when bus_psen_n or bus_rd_n is 0, at any address.
- R9: Reset clears dac12_code and both latches to 0. A register write takes effect in the cycle after the rising edge of bus_wr_n is seen, and a write not decoded per R1 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for write capture and registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Bus address |
| bus_data | input | 8 | Write data from the controller |
| bus_rd_n | input | 1 | Data read strobe, active low |
| bus_wr_n | input | 1 | Data write strobe, active low |
| bus_psen_n | input | 1 | Program fetch strobe, active low |
| mem_rd_n | output | 1 | Combined memory read strobe, active low |
| dac8_cs_n | output | 1 | 8-bit DAC latch select, active low |
| lcd_en | output | 1 | LCD select |
| lcd_rs | output | 1 | LCD register select |
| lcd_rw | output | 1 | LCD read/write select |
| adc_start_n | output | 1 | ADC conversion start, active low |
| adc_rd_hi_n | output | 1 | ADC high result byte read, active low |
| adc_rd_lo_n | output | 1 | ADC low result byte read, active low |
| dac12_code | output | 12 | Committed 12-bit DAC code |

## Verification
The bench looks for leaks through the decode gate. It drives fetches, upper-half addresses and idle bus states at addresses that would otherwise select a peripheral. A decoder that ignored the fetch strobe or address bit 15 would then raise a select during a program fetch or a memory access.

It loads both latches and checks that the output holds until the transfer page is written. A single-buffered design would show the new code too early.

It writes a high byte with the upper nibble set, and checks that those bits do not reach the code. It also writes to the transfer page with bit 15 set or with the fetch strobe low. A design that dropped part of the gate would commit on those writes.

// File: rtl/bus_io_decoder_pkg.sv
package bus_io_decoder_pkg;
  typedef enum logic [2:0] {
    PG_DAC8  = 3'd0,
    PG_LCD   = 3'd1,
    PG_ADC   = 3'd2,
    PG_FREE3 = 3'd3,
    PG_LOAD  = 3'd4,
    PG_XFER  = 3'd5,
    PG_FREE6 = 3'd6,
    PG_FREE7 = 3'd7
  } page_t;

  // page number of a lower-half address
  function automatic page_t page_of(input logic [15:0] a);
    return page_t'(a[14:12]);
  endfunction

  // true when an address lies in the decoded lower half and no fetch is active
  function automatic logic io_window(input logic [15:0] a, input logic psen_n);
    return (a[15] == 1'b0) && psen_n;
  endfunction
endpackage

// File: rtl/iodec_strobe.sv
module iodec_strobe
  import bus_io_decoder_pkg::*;
(
  input  logic [15:0] addr,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic        psen_n,
  output logic        mem_rd_n,
  output logic        dac8_cs_n,
  output logic        lcd_en,
  output logic        lcd_rs,
  output logic        lcd_rw,
  output logic        adc_start_n,
  output logic        adc_rd_hi_n,
  output logic        adc_rd_lo_n
);
  logic  dec_en;
  page_t pg;

  always_comb begin
    dec_en   = io_window(addr, psen_n) && (!rd_n || !wr_n);
    pg       = page_of(addr);
    mem_rd_n = psen_n & rd_n;

    dac8_cs_n   = !(dec_en && pg == PG_DAC8 && !wr_n);
    lcd_en      = dec_en && pg == PG_LCD;
    lcd_rs      = lcd_en & addr[0];
    lcd_rw      = lcd_en & addr[1];
    adc_start_n = !(dec_en && pg == PG_ADC && !wr_n);
    adc_rd_hi_n = !(dec_en && pg == PG_ADC && !rd_n && wr_n && addr[0]);
    adc_rd_lo_n = !(dec_en && pg == PG_ADC && !rd_n && wr_n && !addr[0]);
  end
endmodule

// File: rtl/iodec_wr_capture.sv
module iodec_wr_capture #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              wr_n,
  input  logic              psen_n,
  output logic              wr_done,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data,
  output logic              cap_psen_n
);
  logic wr_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_n_q     <= 1'b1;
      cap_addr   <= '0;
      cap_data   <= '0;
      cap_psen_n <= 1'b1;
    end else begin
      wr_n_q <= wr_n;
      if (!wr_n) begin
        cap_addr   <= addr;
        cap_data   <= data;
        cap_psen_n <= psen_n;
      end
    end
  end

  assign wr_done = wr_n && !wr_n_q;
endmodule

// File: rtl/iodec_dac12.sv
module iodec_dac12 #(
  parameter int DATA_W = 8,
  parameter int DAC_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic              load_hi,
  input  logic              xfer_evt,
  input  logic [DATA_W-1:0] wdata,
  output logic [DAC_W-1:0]  code
);
  localparam int HI_W = DAC_W - DATA_W;

  logic [DATA_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
      code <= '0;
    end else begin
      if (load_evt && !load_hi) lo_q <= wdata;
      if (load_evt && load_hi)  hi_q <= wdata[HI_W-1:0];
      if (xfer_evt)             code <= {hi_q, lo_q};
    end
  end
endmodule

// File: rtl/bus_io_decoder.sv
module bus_io_decoder
  import bus_io_decoder_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DAC_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  input  logic              bus_psen_n,
  output logic              mem_rd_n,
  output logic              dac8_cs_n,
  output logic              lcd_en,
  output logic              lcd_rs,
  output logic              lcd_rw,
  output logic              adc_start_n,
  output logic              adc_rd_hi_n,
  output logic              adc_rd_lo_n,
  output logic [DAC_W-1:0]  dac12_code
);
  logic              wr_done;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic              cap_psen_n;
  logic              load_evt;
  logic              xfer_evt;

  iodec_strobe u_strobe (
    .addr        (bus_addr),
    .rd_n        (bus_rd_n),
    .wr_n        (bus_wr_n),
    .psen_n      (bus_psen_n),
    .mem_rd_n    (mem_rd_n),
    .dac8_cs_n   (dac8_cs_n),
    .lcd_en      (lcd_en),
    .lcd_rs      (lcd_rs),
    .lcd_rw      (lcd_rw),
    .adc_start_n (adc_start_n),
    .adc_rd_hi_n (adc_rd_hi_n),
    .adc_rd_lo_n (adc_rd_lo_n)
  );

  iodec_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (bus_addr),
    .data       (bus_data),
    .wr_n       (bus_wr_n),
    .psen_n     (bus_psen_n),
    .wr_done    (wr_done),
    .cap_addr   (cap_addr),
    .cap_data   (cap_data),
    .cap_psen_n (cap_psen_n)
  );

  // register events: a completed write inside the decoded window
  always_comb begin
    load_evt = wr_done && io_window(cap_addr, cap_psen_n) && page_of(cap_addr) == PG_LOAD;
    xfer_evt = wr_done && io_window(cap_addr, cap_psen_n) && page_of(cap_addr) == PG_XFER;
  end

  iodec_dac12 #(.DATA_W(DATA_W), .DAC_W(DAC_W)) u_dac12 (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .load_hi  (cap_addr[0]),
    .xfer_evt (xfer_evt),
    .wdata    (cap_data),
    .code     (dac12_code)
  );
endmodule

// File: rtl/bus_io_decoder_chk.sv
module bus_io_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] bus_addr,
  input logic        bus_rd_n,
  input logic        bus_wr_n,
  input logic        bus_psen_n,
  input logic        mem_rd_n,
  input logic        dac8_cs_n,
  input logic        lcd_en,
  input logic        lcd_rs,
  input logic        lcd_rw,
  input logic        adc_start_n,
  input logic        adc_rd_hi_n,
  input logic        adc_rd_lo_n,
  input logic [11:0] dac12_code,
  input logic        xfer_evt
);
  logic any_strobe;
  assign any_strobe = !dac8_cs_n || lcd_en || !adc_start_n || !adc_rd_hi_n || !adc_rd_lo_n;

  AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[15] || !bus_psen_n || (bus_rd_n && bus_wr_n)) |-> !any_strobe); // R1
  AST_DAC8_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_n |-> dac8_cs_n); // R2
  AST_LCD_LINES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_en |-> (!lcd_rs && !lcd_rw)); // R3
  AST_ADC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!adc_start_n, !adc_rd_hi_n, !adc_rd_lo_n})); // R4
  AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_evt |=> $stable(dac12_code)); // R6
  AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_addr[15] && bus_addr[14:12] inside {3'd3, 3'd6, 3'd7}) |-> !any_strobe); // R7
  AST_MEM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_psen_n) |-> !mem_rd_n); // R8
endmodule

bind bus_io_decoder bus_io_decoder_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_rd_n    (bus_rd_n),
  .bus_wr_n    (bus_wr_n),
  .bus_psen_n  (bus_psen_n),
  .mem_rd_n    (mem_rd_n),
  .dac8_cs_n   (dac8_cs_n),
  .lcd_en      (lcd_en),
  .lcd_rs      (lcd_rs),
  .lcd_rw      (lcd_rw),
  .adc_start_n (adc_start_n),
  .adc_rd_hi_n (adc_rd_hi_n),
  .adc_rd_lo_n (adc_rd_lo_n),
  .dac12_code  (dac12_code),
  .xfer_evt    (xfer_evt)
);

// File: tb/bus_io_decoder_bench.sv
module bus_io_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        bus_rd_n = 1'b1, bus_wr_n = 1'b1, bus_psen_n = 1'b1;
  logic        mem_rd_n, dac8_cs_n, lcd_en, lcd_rs, lcd_rw;
  logic        adc_start_n, adc_rd_hi_n, adc_rd_lo_n;
  logic [11:0] dac12_code;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_io_decoder u_bus_io_decoder (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_psen_n(bus_psen_n),
    .mem_rd_n(mem_rd_n), .dac8_cs_n(dac8_cs_n), .lcd_en(lcd_en),
    .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .adc_start_n(adc_start_n),
    .adc_rd_hi_n(adc_rd_hi_n), .adc_rd_lo_n(adc_rd_lo_n), .dac12_code(dac12_code)
  );

  // {addr, rd_n, wr_n, psen_n, expected {mem, dac8, lcd_en, rs, rw, start, hi, lo}}
  localparam int NV = 14;
  localparam logic [26:0] VEC [NV] = '{
    {16'h0123, 3'b101, 8'b10000111},   // R2 write page 0
    {16'h0123, 3'b011, 8'b01000111},   // R2 read page 0, R8
    {16'h1003, 3'b101, 8'b11111111},   // R3 lcd write
    {16'h1002, 3'b011, 8'b01101111},   // R3 lcd read
    {16'h2000, 3'b101, 8'b11000011},   // R4 start
    {16'h2001, 3'b011, 8'b01000101},   // R4 high byte
    {16'h2FFE, 3'b011, 8'b01000110},   // R4 low byte
    {16'h3000, 3'b101, 8'b11000111},   // R7
    {16'h6000, 3'b011, 8'b01000111},   // R7
    {16'h7FFF, 3'b101, 8'b11000111},   // R7
    {16'h8000, 3'b011, 8'b01000111},   // R1 upper half, R8
    {16'h0123, 3'b100, 8'b01000111},   // R1 fetch blocks decode, R8
    {16'h1003, 3'b111, 8'b11000111},   // R1 idle bus
    {16'hC000, 3'b110, 8'b01000111}    // R8 fetch in upper half
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic psen);
    @(negedge clk);
    bus_addr = a; bus_data = d; bus_psen_n = psen; bus_wr_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    bus_wr_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_psen_n = 1'b1;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset code", 32'(dac12_code), 32'h000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      bus_addr   = VEC[i][26:11];
      bus_rd_n   = VEC[i][10];
      bus_wr_n   = VEC[i][9];
      bus_psen_n = VEC[i][8];
      #2;
      check($sformatf("R1-strobe vector %0d", i),
            32'({mem_rd_n, dac8_cs_n, lcd_en, lcd_rs, lcd_rw, adc_start_n, adc_rd_hi_n, adc_rd_lo_n}),
            32'(VEC[i][7:0]));
      bus_rd_n = 1'b1; bus_wr_n = 1'b1; bus_psen_n = 1'b1;
      @(negedge clk);
    end

    bus_write(16'h4000, 8'h5A, 1'b1);
    bus_write(16'h4001, 8'hF3, 1'b1);
    check("R6 latches alone", 32'(dac12_code), 32'h000);
    bus_write(16'h5000, 8'h00, 1'b1);
    check("R5 R6 transfer, high nibble only", 32'(dac12_code), 32'h35A);
    bus_write(16'h4000, 8'h11, 1'b1);
    check("R6 hold after low load", 32'(dac12_code), 32'h35A);
    bus_write(16'h3000, 8'hFF, 1'b1);
    bus_write(16'h6ABC, 8'hFF, 1'b1);
    check("R7 unused pages", 32'(dac12_code), 32'h35A);
    bus_write(16'h5000, 8'h00, 1'b0);
    check("R9 fetch blocks transfer", 32'(dac12_code), 32'h35A);
    bus_write(16'hD000, 8'h00, 1'b1);
    check("R9 upper half blocks transfer", 32'(dac12_code), 32'h35A);
    bus_write(16'h5FFF, 8'h00, 1'b1);
    check("R6 transfer new low", 32'(dac12_code), 32'h311);
    bus_write(16'h4FFF, 8'h0C, 1'b1);
    bus_write(16'h5123, 8'h00, 1'b1);
    check("R5 high latch via bit0", 32'(dac12_code), 32'hC11);

    // R9: commit lands the cycle after the write strobe rises
    @(negedge clk);
    bus_addr = 16'h4000; bus_data = 8'h77; bus_wr_n = 1'b0;
    @(negedge clk);
    bus_wr_n = 1'b1;
    @(negedge clk);
    bus_addr = 16'h5000; bus_wr_n = 1'b0;
    @(negedge clk);
    bus_wr_n = 1'b1;
    check("R9 before rising edge seen", 32'(dac12_code), 32'hC11);
    @(negedge clk);
    check("R9 after rising edge", 32'(dac12_code), 32'hC77);

    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset clears code", 32'(dac12_code), 32'h000);
    rst_n = 1'b1;
    bus_write(16'h5000, 8'h00, 1'b1);
    check("R9 reset clears latches", 32'(dac12_code), 32'h000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule